// File: doc/BRIEF.md
# I2C Master Stop and Wait Controller

This block handles the byte-boundary side of an I2C master. A bit engine elsewhere reports each completed SCL clock of a byte, together with its index. At a configured point in the byte this block holds SCL low and raises a one-cycle interrupt. The point is either after the 8th clock or after the 9th (acknowledge) clock. Software then resumes the transfer in one of two ways: it issues a wait-release command, or it writes the next data byte.

Software can also ask for a stop condition. The block accepts the request only in master mode, and it refuses a request made together with a start request. It keeps the request pending until the next wait point. It then drives SDA low and releases SCL. It waits until it sees SCL high on the synchronized bus line, so a slave that stretches the clock delays the stop. It then counts a programmable setup interval and releases SDA, so that SDA rises while SCL is high. When the request is made at an 8th-clock wait, the release of SCL is the 9th clock, so the stop lands in that clock's high phase. The pending request clears when the stop is seen on the bus, and also on arbitration loss, on a bus-release command, when the block is disabled, and at reset.

Both line outputs are open-drain enables: 1 pulls the line low. The SCL and SDA inputs pass through a synchronizer before any use.

Top module: `i2c_stop_wait_ctrl`

## Requirements
- R1: After reset, scl_oe, sda_oe, irq, stop_pend, start_go and tx_flag are all 0.
- R2: With wait_after9 = 0 a clk_done pulse with clk_idx = 8 enters the wait state. With wait_after9 = 1 a pulse with clk_idx = 9 enters it. The wait state shows as scl_oe = 1 from the cycle after the pulse. Any other index leaves scl_oe at 0.
- R3: irq is a single-cycle pulse, high in the first cycle of each wait state and never for a pulse that enters no wait.
- R4: The wait state ends, with scl_oe back to 0 one cycle later, on cmd_rel, on cmd_wr_data, on cmd_lrel, or when enable is low.
- R5: cmd_wr_data loads tx_flag from wr_tx_dir. While tx_flag is 1, data_sda_low drives sda_oe. A cmd_rel given during a wait after the 9th clock clears tx_flag, so sda_oe goes to 0 even with data_sda_low held at 1.
- R6: cmd_stop sets stop_pend only when enable and master_mode are both 1. In any other case stop_pend stays 0.
- R7: cmd_start and cmd_stop in the same cycle are both refused: no start_go pulse and no stop_pend. cmd_start alone gives a one-cycle start_go pulse.
- R8: A stop drives SDA low while SCL is still held low, then releases SCL. SDA is released only while SCL is high, and at least the setup interval after SCL is seen high.
- R9: A stop requested in a wait after the 8th clock produces exactly one SCL rising edge, the 9th clock, and SDA rises during that high phase.
- R10: A stop requested in a wait after the 9th clock ends the wait and leaves both lines released once the stop is complete.
- R11: While a slave holds SCL low after the release, SDA stays driven low. The setup interval starts only once SCL is seen high.
- R12: A setup_cycles value of 0 behaves exactly like 1. Each further count lengthens the SCL-high phase before SDA rises by one cycle.
- R13: stop_pend clears when a stop is detected on the bus, on arb_lost, on cmd_lrel, and when enable is low. A request made outside a wait stays pending until one of these occurs or a wait point arrives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| enable | input | 1 | Module enable; low cancels waits and pending stops |
| master_mode | input | 1 | Controller currently owns the bus as master |
| wait_after9 | input | 1 | 0: wait after 8th clock, 1: wait after 9th clock |
| setup_cycles | input | SETUP_W | Stop setup interval in clock cycles (0 treated as 1) |
| clk_done | input | 1 | Pulse: one SCL clock of the byte has completed |
| clk_idx | input | CNT_W | Index (1..9) of the clock that completed |
| cmd_start | input | 1 | Start request pulse |
| cmd_stop | input | 1 | Stop request pulse |
| cmd_rel | input | 1 | Wait-release command pulse |
| cmd_wr_data | input | 1 | Data register write pulse |
| cmd_lrel | input | 1 | Bus-release command pulse |
| wr_tx_dir | input | 1 | Direction qualifying cmd_wr_data: 1 = transmit |
| arb_lost | input | 1 | Arbitration loss pulse |
| data_sda_low | input | 1 | Shifter wants SDA low for the current data bit |
| scl_in | input | 1 | SCL line state (asynchronous) |
| sda_in | input | 1 | SDA line state (asynchronous) |
| scl_oe | output | 1 | Pull SCL low |
| sda_oe | output | 1 | Pull SDA low |
| irq | output | 1 | Wait-point interrupt pulse |
| stop_pend | output | 1 | A stop request is pending or in progress |
| start_go | output | 1 | Accepted start request pulse to the start generator |
| tx_flag | output | 1 | Controller is transmitting the current byte |

## Verification
The properties assume that command inputs are single-cycle pulses and that clk_done arrives only while no wait is held. They also assume that once SCL has been seen high during a stop, nothing pulls it low again before SDA rises. The bench keeps to these rules. It issues each command on its own between idle cycles. It models each bus line as the wired-AND of the block's output enable and, for SCL, an optional slave hold. It lowers that slave hold only once, and never after the stop has seen SCL high.

// File: rtl/i2c_sw_pkg.sv
// Shared definitions for the I2C stop and wait controller.
// Assumes: byte clocks are indexed 1..9, the 9th being the acknowledge clock.
package i2c_sw_pkg;

    // Stop sequence phases, in the order they run
    typedef enum logic [2:0] {
        SG_IDLE,      // nothing in progress
        SG_SDA_LOW,   // SDA pulled low while SCL still held low
        SG_SCL_REL,   // SCL released, waiting to see it high
        SG_SETUP,     // SCL high, counting setup interval
        SG_SDA_REL    // SDA released, waiting for stop detection
    } stop_state_e;

    localparam int unsigned WAIT_IDX_8 = 8;
    localparam int unsigned WAIT_IDX_9 = 9;

endpackage

// File: rtl/i2c_sw_line_sync.sv
// Multi-stage synchronizer for a set of bus lines.
// What it does: for each line it gives the synchronized value and the value one cycle older.
// Assumes: idle bus lines are high, so every stage resets to 1.
module i2c_sw_line_sync #(
    parameter int STAGES = 2,
    parameter int LINES  = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LINES-1:0] line_in,
    output logic [LINES-1:0] line_s,
    output logic [LINES-1:0] line_prev
);

    generate
        for (genvar g = 0; g < LINES; g++) begin : g_line
            logic [STAGES:0] shreg;

            // Shift the asynchronous line through the synchronizer plus one history stage
            always_ff @(posedge clk) begin
                if (!rst_n) shreg <= '1;
                else        shreg <= {shreg[STAGES-1:0], line_in[g]};
            end

            assign line_s[g]    = shreg[STAGES-1];
            assign line_prev[g] = shreg[STAGES];
        end
    endgenerate

endmodule

// File: rtl/i2c_sw_wait_ctl.sv
// Wait-point controller.
// What it does: holds SCL low after the configured clock of each byte, raises the interrupt,
// and keeps the transmit flag.
// Assumes: clk_done is a single-cycle pulse and commands are single-cycle pulses.
module i2c_sw_wait_ctl
    import i2c_sw_pkg::*;
#(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic             wait_after9,
    input  logic             clk_done,
    input  logic [CNT_W-1:0] clk_idx,
    input  logic             cmd_rel,
    input  logic             cmd_wr_data,
    input  logic             wr_tx_dir,
    input  logic             cmd_lrel,
    input  logic             stop_take,
    output logic             wait_hold,
    output logic             irq,
    output logic             tx_flag
);

    localparam logic [CNT_W-1:0] IDX8 = CNT_W'(WAIT_IDX_8);
    localparam logic [CNT_W-1:0] IDX9 = CNT_W'(WAIT_IDX_9);

    logic wait_q, at9_q, irq_q, tx_q;
    logic hit, release_w;

    // Decide whether this clock completion is the configured wait point
    always_comb begin
        hit = enable && clk_done && (clk_idx == (wait_after9 ? IDX9 : IDX8));
    end

    // Collect every event that ends a wait
    always_comb begin
        release_w = cmd_rel || cmd_wr_data || cmd_lrel || !enable || stop_take;
    end

    // Wait state, its kind, and the interrupt pulse
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wait_q <= 1'b0;
            at9_q  <= 1'b0;
            irq_q  <= 1'b0;
        end else begin
            irq_q <= hit && !release_w;
            if (release_w) begin
                wait_q <= 1'b0;
            end else if (hit) begin
                wait_q <= 1'b1;
                at9_q  <= wait_after9;
            end
        end
    end

    // Transmit flag: loaded on data write, dropped on release during an acknowledge-clock wait
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_q <= 1'b0;
        end else if (!enable || cmd_lrel) begin
            tx_q <= 1'b0;
        end else if (cmd_wr_data) begin
            tx_q <= wr_tx_dir;
        end else if (cmd_rel && wait_q && at9_q) begin
            tx_q <= 1'b0;
        end
    end

    assign wait_hold = wait_q;
    assign irq       = irq_q;
    assign tx_flag   = tx_q;

    AST_IRQ_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        irq_q |=> !irq_q); // R3
    AST_WAIT_ENDS_ON_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        (wait_q && (cmd_rel || cmd_wr_data)) |=> !wait_q); // R4
    AST_TX_DROP_AT_ACK_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_q && wait_q && at9_q && cmd_rel && !cmd_wr_data) |=> !tx_q); // R5

endmodule

// File: rtl/i2c_sw_stop_gen.sv
// Stop trigger and stop-condition sequencer.
// What it does: accepts stop and start requests, keeps the stop trigger, and at a wait point
// runs SDA low, SCL release, observed-high, setup, SDA release.
// Assumes: scl_s and stop_det come from synchronized lines, and commands are single-cycle pulses.
module i2c_sw_stop_gen
    import i2c_sw_pkg::*;
#(
    parameter int SETUP_W = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               enable,
    input  logic               master_mode,
    input  logic               cmd_start,
    input  logic               cmd_stop,
    input  logic               cmd_lrel,
    input  logic               arb_lost,
    input  logic               stop_det,
    input  logic               wait_active,
    input  logic               scl_s,
    input  logic [SETUP_W-1:0] setup_cycles,
    output logic               stop_pend,
    output logic               start_go,
    output logic               stop_take,
    output logic               scl_hold,
    output logic               sda_drive
);

    stop_state_e        st_q, st_d;
    logic [SETUP_W-1:0] cnt_q, setup_eff;
    logic               trig_q, start_q;
    logic               accept, clr, go, cnt_last;

    // Request qualification and trigger clear sources
    always_comb begin
        accept = cmd_stop && !cmd_start && master_mode && enable;
        clr    = stop_det || arb_lost || cmd_lrel || !enable;
        go     = trig_q && wait_active && (st_q == SG_IDLE) && !clr;
    end

    // Effective setup length with a floor of one cycle
    always_comb begin
        setup_eff = (setup_cycles == '0) ? SETUP_W'(1) : setup_cycles;
        cnt_last  = (cnt_q == setup_eff - SETUP_W'(1));
    end

    // Stop trigger and start pass-through registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            trig_q  <= 1'b0;
            start_q <= 1'b0;
        end else begin
            start_q <= cmd_start && !cmd_stop && enable;
            if (clr)         trig_q <= 1'b0;
            else if (accept) trig_q <= 1'b1;
        end
    end

    // Next-state logic for the stop sequence
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            SG_IDLE:    if (go)       st_d = SG_SDA_LOW;
            SG_SDA_LOW: if (cnt_last) st_d = SG_SCL_REL;
            SG_SCL_REL: if (scl_s)    st_d = SG_SETUP;
            SG_SETUP:   if (cnt_last) st_d = SG_SDA_REL;
            SG_SDA_REL: st_d = SG_SDA_REL;
            default:    st_d = SG_IDLE;
        endcase
        if (clr && st_q != SG_IDLE) st_d = SG_IDLE;
    end

    // State register and phase counter
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q  <= SG_IDLE;
            cnt_q <= '0;
        end else begin
            st_q <= st_d;
            if (st_d != st_q)
                cnt_q <= '0;
            else if (st_q == SG_SDA_LOW || st_q == SG_SETUP)
                cnt_q <= cnt_q + SETUP_W'(1);
        end
    end

    assign stop_pend = trig_q;
    assign start_go  = start_q;
    assign stop_take = go;
    assign scl_hold  = (st_q == SG_SDA_LOW);
    assign sda_drive = (st_q == SG_SDA_LOW) || (st_q == SG_SCL_REL) || (st_q == SG_SETUP);

    AST_STOP_ONLY_MASTER: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(trig_q) |-> $past(master_mode) && $past(enable)); // R6
    AST_NO_DUAL_REQUEST: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_start && cmd_stop) |=> !start_q); // R7
    AST_SDA_UP_WITH_SCL_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == SG_SDA_REL) |-> scl_s); // R8
    AST_ARB_CLEARS_TRIG: assert property (@(posedge clk) disable iff (!rst_n)
        arb_lost |=> !trig_q); // R13

endmodule

// File: rtl/i2c_stop_wait_ctrl.sv
// Top of the I2C master stop and wait controller.
// What it does: synchronizes the bus lines, detects stops, and combines wait hold, stop
// sequence and data drive into the open-drain enables.
// Assumes: scl_in/sda_in are the real line states; an enable of 1 pulls the line low.
module i2c_stop_wait_ctrl #(
    parameter int CNT_W       = 4,
    parameter int SETUP_W     = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               enable,
    input  logic               master_mode,
    input  logic               wait_after9,
    input  logic [SETUP_W-1:0] setup_cycles,
    input  logic               clk_done,
    input  logic [CNT_W-1:0]   clk_idx,
    input  logic               cmd_start,
    input  logic               cmd_stop,
    input  logic               cmd_rel,
    input  logic               cmd_wr_data,
    input  logic               cmd_lrel,
    input  logic               wr_tx_dir,
    input  logic               arb_lost,
    input  logic               data_sda_low,
    input  logic               scl_in,
    input  logic               sda_in,
    output logic               scl_oe,
    output logic               sda_oe,
    output logic               irq,
    output logic               stop_pend,
    output logic               start_go,
    output logic               tx_flag
);

    localparam int LINE_SCL = 0;
    localparam int LINE_SDA = 1;

    logic [1:0] line_s, line_prev;
    logic       stop_det, wait_hold, stop_take, scl_hold, sda_drive;

    i2c_sw_line_sync #(
        .STAGES (SYNC_STAGES),
        .LINES  (2)
    ) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .line_in   ({sda_in, scl_in}),
        .line_s    (line_s),
        .line_prev (line_prev)
    );

    // Stop on the bus: SDA rises while SCL has been high for two samples
    always_comb begin
        stop_det = line_s[LINE_SCL] && line_prev[LINE_SCL]
                && line_s[LINE_SDA] && !line_prev[LINE_SDA];
    end

    i2c_sw_wait_ctl #(
        .CNT_W (CNT_W)
    ) u_wait (
        .clk         (clk),
        .rst_n       (rst_n),
        .enable      (enable),
        .wait_after9 (wait_after9),
        .clk_done    (clk_done),
        .clk_idx     (clk_idx),
        .cmd_rel     (cmd_rel),
        .cmd_wr_data (cmd_wr_data),
        .wr_tx_dir   (wr_tx_dir),
        .cmd_lrel    (cmd_lrel),
        .stop_take   (stop_take),
        .wait_hold   (wait_hold),
        .irq         (irq),
        .tx_flag     (tx_flag)
    );

    i2c_sw_stop_gen #(
        .SETUP_W (SETUP_W)
    ) u_stop (
        .clk          (clk),
        .rst_n        (rst_n),
        .enable       (enable),
        .master_mode  (master_mode),
        .cmd_start    (cmd_start),
        .cmd_stop     (cmd_stop),
        .cmd_lrel     (cmd_lrel),
        .arb_lost     (arb_lost),
        .stop_det     (stop_det),
        .wait_active  (wait_hold),
        .scl_s        (line_s[LINE_SCL]),
        .setup_cycles (setup_cycles),
        .stop_pend    (stop_pend),
        .start_go     (start_go),
        .stop_take    (stop_take),
        .scl_hold     (scl_hold),
        .sda_drive    (sda_drive)
    );

    // Open-drain enables: wait or stop holds SCL, stop or transmit data pulls SDA
    always_comb begin
        scl_oe = wait_hold || scl_hold;
        sda_oe = sda_drive || (tx_flag && data_sda_low);
    end

    AST_OFF_RELEASES_LINES: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> !scl_oe && !sda_oe); // R4
    AST_STOP_HOLDS_SCL_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_drive) |-> scl_oe); // R8

endmodule

// File: tb/i2c_stop_wait_ctrl_tb.sv
module i2c_stop_wait_ctrl_tb;

    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       enable = 1'b1, master_mode = 1'b1, wait_after9 = 1'b0;
    logic [7:0] setup_cycles = 8'd1;
    logic       clk_done = 1'b0;
    logic [3:0] clk_idx = 4'd0;
    logic       cmd_start = 0, cmd_stop = 0, cmd_rel = 0, cmd_wr_data = 0, cmd_lrel = 0;
    logic       wr_tx_dir = 0, arb_lost = 0, data_sda_low = 0, slave_hold = 0;
    logic       scl_oe, sda_oe, irq, stop_pend, start_go, tx_flag;
    wire        scl_in = !(scl_oe || slave_hold);
    wire        sda_in = !sda_oe;

    int checks = 0;
    int failures = 0;

    // cfg[5] | clk_idx[4:1] | expect wait[0]
    localparam logic [5:0] WAIT_VEC [0:5] = '{
        6'b0_1000_1, 6'b0_1001_0, 6'b1_1001_1,
        6'b1_1000_0, 6'b0_0111_0, 6'b1_0011_0
    };

    i2c_stop_wait_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .enable(enable), .master_mode(master_mode),
        .wait_after9(wait_after9), .setup_cycles(setup_cycles), .clk_done(clk_done),
        .clk_idx(clk_idx), .cmd_start(cmd_start), .cmd_stop(cmd_stop), .cmd_rel(cmd_rel),
        .cmd_wr_data(cmd_wr_data), .cmd_lrel(cmd_lrel), .wr_tx_dir(wr_tx_dir),
        .arb_lost(arb_lost), .data_sda_low(data_sda_low), .scl_in(scl_in), .sda_in(sda_in),
        .scl_oe(scl_oe), .sda_oe(sda_oe), .irq(irq), .stop_pend(stop_pend),
        .start_go(start_go), .tx_flag(tx_flag)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    // Give a wait-point clock completion, return at the negedge after it registered
    task automatic give_clk(input logic [3:0] idx);
        @(negedge clk); clk_done = 1'b1; clk_idx = idx;
        @(negedge clk); clk_done = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Issue a stop inside a held wait and watch the bus until SDA rises
    task automatic run_stop(input int hold, output int hi);
        int  rises = 0, hc = 0;
        bit  prev_scl, prev_sda, done = 0, bad = 0;
        hi = 0;
        slave_hold = (hold > 0);
        @(negedge clk); cmd_stop = 1'b1;
        @(negedge clk); cmd_stop = 1'b0;
        chk(stop_pend == 1'b1, "R6 stop accepted in master", int'(stop_pend), 1);
        prev_scl = scl_in; prev_sda = sda_oe;
        for (int i = 0; i < 300 && !done; i++) begin
            @(negedge clk);
            if (!prev_scl && scl_in) begin
                rises++;
                chk(sda_oe == 1'b1, "R8 SDA low at SCL rise", int'(sda_oe), 1);
            end
            if (scl_in && sda_oe) hi++;
            if (prev_sda && !sda_oe) begin
                done = 1;
                chk(scl_in == 1'b1, "R8 SDA rises with SCL high", int'(scl_in), 1);
            end
            prev_scl = scl_in; prev_sda = sda_oe;
            if (slave_hold && !scl_oe) begin
                if (!sda_oe) bad = 1;
                hc++;
                if (hc >= hold) slave_hold = 1'b0;
            end
        end
        slave_hold = 1'b0;
        chk(done, "R8 stop sequence completes", int'(done), 1);
        chk(rises == 1, "R9 single SCL high phase", rises, 1);
        chk(!bad, "R11 SDA held during stretch", int'(bad), 0);
        idle(5);
        chk(stop_pend == 1'b0, "R13 cleared by stop detect", int'(stop_pend), 0);
        chk(!scl_oe && !sda_oe, "R10 lines released after stop", int'({scl_oe, sda_oe}), 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        failures++;
        $display("FAIL WD watchdog expired actual=0 expected=1");
        summary();
    end

    initial begin
        int hi0, hi1, hi4, hs;
        idle(3);
        chk({scl_oe, sda_oe, irq, stop_pend, start_go, tx_flag} == 6'b0,
            "R1 reset state", int'({scl_oe, sda_oe, irq, stop_pend, start_go, tx_flag}), 0);
        @(negedge clk); rst_n = 1'b1;
        idle(3);

        // Wait-point vector table: R2 and R3
        for (int v = 0; v < 6; v++) begin
            wait_after9 = WAIT_VEC[v][5];
            give_clk(WAIT_VEC[v][4:1]);
            chk(scl_oe == WAIT_VEC[v][0], "R2 wait point", int'(scl_oe), int'(WAIT_VEC[v][0]));
            chk(irq == WAIT_VEC[v][0], "R3 irq at wait entry", int'(irq), int'(WAIT_VEC[v][0]));
            @(negedge clk);
            chk(irq == 1'b0, "R3 irq single cycle", int'(irq), 0);
            cmd_rel = 1'b1; @(negedge clk); cmd_rel = 1'b0;
            chk(scl_oe == 1'b0, "R4 release by cmd_rel", int'(scl_oe), 0);
            idle(2);
        end

        // R4: release by data write, and by disabling
        wait_after9 = 1'b0; give_clk(4'd8);
        cmd_wr_data = 1'b1; wr_tx_dir = 1'b0; @(negedge clk); cmd_wr_data = 1'b0;
        chk(scl_oe == 1'b0, "R4 release by data write", int'(scl_oe), 0);
        give_clk(4'd8);
        enable = 1'b0; @(negedge clk); enable = 1'b1;
        chk(scl_oe == 1'b0, "R4 release by enable low", int'(scl_oe), 0);
        idle(2);

        // R5: transmit flag and SDA drive at acknowledge-clock wait
        wait_after9 = 1'b1;
        cmd_wr_data = 1'b1; wr_tx_dir = 1'b1; @(negedge clk); cmd_wr_data = 1'b0; wr_tx_dir = 1'b0;
        chk(tx_flag == 1'b1, "R5 tx flag set by write", int'(tx_flag), 1);
        data_sda_low = 1'b1; #1;
        chk(sda_oe == 1'b1, "R5 data drives SDA", int'(sda_oe), 1);
        give_clk(4'd9);
        cmd_rel = 1'b1; @(negedge clk); cmd_rel = 1'b0;
        chk(tx_flag == 1'b0, "R5 tx flag cleared at 9th wait", int'(tx_flag), 0);
        chk(sda_oe == 1'b0, "R5 SDA released", int'(sda_oe), 0);
        data_sda_low = 1'b0;
        idle(2);

        // R6: stop ignored outside master mode
        master_mode = 1'b0;
        cmd_stop = 1'b1; @(negedge clk); cmd_stop = 1'b0;
        chk(stop_pend == 1'b0, "R6 stop ignored as slave", int'(stop_pend), 0);
        master_mode = 1'b1;

        // R7: start and stop together refused, start alone passes
        cmd_start = 1'b1; cmd_stop = 1'b1; @(negedge clk); cmd_start = 1'b0; cmd_stop = 1'b0;
        chk(start_go == 1'b0 && stop_pend == 1'b0, "R7 dual request refused",
            int'({start_go, stop_pend}), 0);
        cmd_start = 1'b1; @(negedge clk); cmd_start = 1'b0;
        chk(start_go == 1'b1, "R7 start alone", int'(start_go), 1);
        @(negedge clk);
        chk(start_go == 1'b0, "R7 start pulse single", int'(start_go), 0);

        // R13: pending stop cleared by arbitration loss, bus release, disable
        cmd_stop = 1'b1; @(negedge clk); cmd_stop = 1'b0;
        chk(stop_pend == 1'b1 && scl_oe == 1'b0, "R13 pending outside wait",
            int'({stop_pend, scl_oe}), 2);
        arb_lost = 1'b1; @(negedge clk); arb_lost = 1'b0;
        chk(stop_pend == 1'b0, "R13 cleared by arb_lost", int'(stop_pend), 0);
        cmd_stop = 1'b1; @(negedge clk); cmd_stop = 1'b0;
        cmd_lrel = 1'b1; @(negedge clk); cmd_lrel = 1'b0;
        chk(stop_pend == 1'b0, "R13 cleared by bus release", int'(stop_pend), 0);
        cmd_stop = 1'b1; @(negedge clk); cmd_stop = 1'b0;
        enable = 1'b0; @(negedge clk); enable = 1'b1;
        chk(stop_pend == 1'b0, "R13 cleared by disable", int'(stop_pend), 0);
        idle(2);

        // R10: stop at 9th-clock wait (receiver acknowledging the last byte)
        wait_after9 = 1'b1; setup_cycles = 8'd1;
        give_clk(4'd9); idle(4);
        run_stop(0, hi1);

        // R9: stop at 8th-clock wait lands in the 9th clock high phase
        wait_after9 = 1'b0;
        give_clk(4'd8); idle(4);
        run_stop(0, hs);
        chk(hs == hi1, "R9 same timing at 8th wait", hs, hi1);

        // R12: zero setup equals one, larger setup lengthens high phase
        setup_cycles = 8'd0;
        give_clk(4'd8); idle(4);
        run_stop(0, hi0);
        chk(hi0 == hi1, "R12 setup 0 acts as 1", hi0, hi1);
        setup_cycles = 8'd4;
        give_clk(4'd8); idle(4);
        run_stop(0, hi4);
        chk(hi4 == hi1 + 3, "R12 setup lengthens SCL high", hi4, hi1 + 3);
        chk(hi4 >= 4, "R8 setup interval honoured", hi4, 4);

        // R11: slave stretching delays the setup interval
        setup_cycles = 8'd2; wait_after9 = 1'b1;
        give_clk(4'd9); idle(4);
        run_stop(6, hs);
        chk(hs >= 2, "R11 setup counted after SCL high", hs, 2);

        summary();
    end

endmodule